// File: doc/BRIEF.md
# Dual-Mode Receive Deserializer

This block turns a serial bit stream into bytes for a host. An upstream demodulator hands it one bit at a time, each with a single-cycle strobe. The block assembles those bits into a receive data register. It raises a byte-available flag when a byte lands there and a sticky parity-error flag when a checked character arrives with bad parity.

Two receive modes are supported:

- **Synchronous mode.** The block collects raw groups of `DATA_W` bits with no framing. The first bit of each group becomes bit 0.
- **Asynchronous mode.** The block hunts for a start bit at space (0). It gathers 7 or 8 data bits, least significant first, and optionally checks a parity bit. It then needs one stop bit at mark (1) and tolerates any run of idle marks before the next start.

The configuration inputs carry the fields of the mode register that the transmit side also decodes:

| Config input | Mode register bit | Meaning |
|---|---|---|
| `cfg_len8` | 0 | 1 = 8 data bits, 0 = 7 data bits |
| `cfg_odd` | 1 | 1 = odd parity, 0 = even parity |
| `cfg_par_en` | 2 | 1 = a parity bit follows the data |
| `cfg_async` | 5 | 1 = asynchronous mode, 0 = synchronous mode |

Top module: `dual_rx_deser`

## Requirements
- R1: With `cfg_async`=0, every `DATA_W` (8) strobed bits are transferred to `rx_data` in the clock edge that samples the last of them. The first bit of the group goes to bit 0.
- R2: Each time synchronous mode is entered (`cfg_async` goes from 1 to 0), the bit position restarts, so the first strobed bit afterwards lands in bit 0.
- R3: With `cfg_async`=1 and no character in progress, strobed marks (1) are ignored: nothing is transferred and the flags do not change. A strobed space (0) starts a character.
- R4: `cfg_len8`=1 selects 8 data bits and `cfg_len8`=0 selects 7. The first data bit after the start bit goes to bit 0. In 7-bit mode, bit 7 of `rx_data` is written as 0.
- R5: With `cfg_par_en`=1, one parity bit follows the data bits. Even parity (`cfg_odd`=0) expects an even count of ones over data plus parity; odd parity (`cfg_odd`=1) expects an odd count. A mismatch sets `par_err` when the character is transferred.
- R6: `par_err` stays set until `par_clr` is pulsed. A correct character does not clear it.
- R7: A mark in the bit position after the data (and parity) completes the character and transfers it. Any number of further marks may follow before the next start bit.
- R8: A space in the stop position discards the character. No byte is transferred, no flag changes, and the receiver goes back to hunting for a start bit.
- R9: `byte_avail` is set by a transfer and cleared by an `rx_rd` pulse. A transfer in the same cycle as `rx_rd` leaves it set.
- R10: A new transfer overwrites an unread byte in `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-cycle strobe marking a valid incoming bit |
| bit_in | input | 1 | Incoming serial bit (1 = mark, 0 = space) |
| cfg_async | input | 1 | Mode register bit 5: 1 = asynchronous, 0 = synchronous |
| cfg_len8 | input | 1 | Mode register bit 0: 1 = 8 data bits, 0 = 7 |
| cfg_odd | input | 1 | Mode register bit 1: 1 = odd parity, 0 = even |
| cfg_par_en | input | 1 | Mode register bit 2: parity bit present and checked |
| rx_rd | input | 1 | Host read pulse; clears `byte_avail` |
| par_clr | input | 1 | Host pulse that clears `par_err` |
| rx_data | output | DATA_W | Receive data register |
| byte_avail | output | 1 | A transferred byte is waiting |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
The bench builds the block with the default `DATA_W` of 8. This makes the 7-bit and 8-bit character lengths and the raw 8-bit synchronous group match the byte-wide stimulus. Random characters mix lengths, parity settings, deliberately wrong parity bits, long idle-mark runs and strobe gaps. Directed cases cover the mode switch mid-group, a space in the stop position, overwriting an unread byte and clearing the sticky flag.

// File: rtl/dual_rx_deser_pkg.sv
package dual_rx_deser_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_DATA = 2'd1,
      ST_PAR  = 2'd2,
      ST_STOP = 2'd3
   } rx_st_e;
endpackage

// File: rtl/rx_sync_collect.sv
module rx_sync_collect #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stb,
   input  logic              bit_in,
   output logic              push,
   output logic [DATA_W-1:0] push_data
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  pos_q;
   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         sh_q  <= '0;
      end else if (!en) begin
         pos_q <= '0;
      end else if (stb) begin
         sh_q[pos_q] <= bit_in;
         pos_q       <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
      end
   end

   assign push      = en && stb && (pos_q == LAST);
   assign push_data = {bit_in, sh_q[DATA_W-2:0]};

   // R2: leaving synchronous mode always leaves the group position at zero
   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |=> (pos_q == '0));
endmodule

// File: rtl/rx_async_frame.sv
module rx_async_frame
   import dual_rx_deser_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stb,
   input  logic              bit_in,
   input  logic              len8,
   input  logic              odd,
   input  logic              par_en,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              push_perr
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

   rx_st_e            st_q;
   logic [CNT_W-1:0]  pos_q;
   logic [DATA_W-1:0] sh_q;
   logic              acc_q;
   logic              bad_q;
   logic [CNT_W-1:0]  last_pos;

   assign last_pos = len8 ? LAST_LONG : LAST_SHORT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_HUNT;
         pos_q <= '0;
         sh_q  <= '0;
         acc_q <= 1'b0;
         bad_q <= 1'b0;
      end else if (!en) begin
         st_q  <= ST_HUNT;
         pos_q <= '0;
      end else if (stb) begin
         unique case (st_q)
            ST_HUNT: begin
               if (!bit_in) begin
                  st_q  <= ST_DATA;
                  pos_q <= '0;
                  acc_q <= 1'b0;
                  bad_q <= 1'b0;
               end
            end
            ST_DATA: begin
               sh_q[pos_q] <= bit_in;
               acc_q       <= acc_q ^ bit_in;
               if (pos_q == last_pos) begin
                  st_q <= par_en ? ST_PAR : ST_STOP;
               end else begin
                  pos_q <= pos_q + 1'b1;
               end
            end
            ST_PAR: begin
               bad_q <= (acc_q ^ bit_in) != odd;
               st_q  <= ST_STOP;
            end
            ST_STOP: begin
               st_q <= ST_HUNT;
            end
            default: st_q <= ST_HUNT;
         endcase
      end
   end

   assign push      = en && stb && (st_q == ST_STOP) && bit_in;
   assign push_data = len8 ? sh_q : {1'b0, sh_q[DATA_W-2:0]};
   assign push_perr = bad_q;

   // R3: an idle mark never starts a character
   p_idle_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && stb && bit_in && st_q == ST_HUNT) |=> (st_q == ST_HUNT));
   // R8: a space in the stop slot returns to hunting
   p_stop_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && stb && !bit_in && st_q == ST_STOP) |=> (st_q == ST_HUNT));
endmodule

// File: rtl/rx_host_reg.sv
module rx_host_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_perr,
   input  logic              rd,
   input  logic              perr_clr,
   output logic [DATA_W-1:0] data_q,
   output logic              avail_q,
   output logic              perr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         avail_q <= 1'b0;
         perr_q  <= 1'b0;
      end else begin
         if (push) data_q <= push_data;
         if (push)    avail_q <= 1'b1;
         else if (rd) avail_q <= 1'b0;
         if (push && push_perr) perr_q <= 1'b1;
         else if (perr_clr)     perr_q <= 1'b0;
      end
   end

   p_avail_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> avail_q);
   p_avail_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !push) |=> !avail_q);
   p_perr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_q && !perr_clr) |=> perr_q);
endmodule

// File: rtl/dual_rx_deser.sv
module dual_rx_deser #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_in,
   input  logic              cfg_async,
   input  logic              cfg_len8,
   input  logic              cfg_odd,
   input  logic              cfg_par_en,
   input  logic              rx_rd,
   input  logic              par_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              byte_avail,
   output logic              par_err
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dual_rx_deser: DATA_W must be at least 2");
      end
   endgenerate

   logic              s_push, a_push, a_perr, h_push, h_perr;
   logic [DATA_W-1:0] s_data, a_data, h_data;

   rx_sync_collect #(.DATA_W(DATA_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .en(!cfg_async), .stb(bit_stb), .bit_in(bit_in),
      .push(s_push), .push_data(s_data)
   );

   rx_async_frame #(.DATA_W(DATA_W)) u_async (
      .clk(clk), .rst_n(rst_n), .en(cfg_async), .stb(bit_stb), .bit_in(bit_in),
      .len8(cfg_len8), .odd(cfg_odd), .par_en(cfg_par_en),
      .push(a_push), .push_data(a_data), .push_perr(a_perr)
   );

   assign h_push = s_push | a_push;
   assign h_data = a_push ? a_data : s_data;
   assign h_perr = a_push & a_perr;

   rx_host_reg #(.DATA_W(DATA_W)) u_host (
      .clk(clk), .rst_n(rst_n), .push(h_push), .push_data(h_data),
      .push_perr(h_perr), .rd(rx_rd), .perr_clr(par_clr),
      .data_q(rx_data), .avail_q(byte_avail), .perr_q(par_err)
   );

   // R1: the two collectors never deliver in the same cycle
   p_one_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_push && a_push));
   // R4: a short character leaves the top data bit clear
   p_short_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_push && !cfg_len8) |=> (rx_data[DATA_W-1] == 1'b0));
endmodule

// File: tb/dual_rx_deser_test.sv
module dual_rx_deser_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_stb = 1'b0, bit_in = 1'b1;
   logic cfg_async = 1'b1, cfg_len8 = 1'b1, cfg_odd = 1'b0, cfg_par_en = 1'b0;
   logic rx_rd = 1'b0, par_clr = 1'b0;
   logic [7:0] rx_data;
   logic byte_avail, par_err;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   dual_rx_deser #(.DATA_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
      .cfg_async(cfg_async), .cfg_len8(cfg_len8), .cfg_odd(cfg_odd),
      .cfg_par_en(cfg_par_en), .rx_rd(rx_rd), .par_clr(par_clr),
      .rx_data(rx_data), .byte_avail(byte_avail), .par_err(par_err)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic exp_par(input logic [7:0] d, input logic l8, input logic odd);
      logic [7:0] m = l8 ? d : {1'b0, d[6:0]};
      return odd ? ~^m : ^m;
   endfunction

   task automatic send_bit(input logic b, input int gap);
      @(negedge clk); bit_stb = 1'b1; bit_in = b;
      @(negedge clk); bit_stb = 1'b0; bit_in = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input logic badp,
                            input logic stopv, input int extra, input int gap);
      send_bit(1'b0, gap);
      for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) send_bit(d[i], gap);
      if (cfg_par_en) send_bit(exp_par(d, cfg_len8, cfg_odd) ^ badp, gap);
      send_bit(stopv, gap);
      for (int i = 0; i < extra; i++) send_bit(1'b1, gap);
   endtask

   task automatic host_read();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   task automatic clear_perr();
      @(negedge clk); par_clr = 1'b1;
      @(negedge clk); par_clr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d, d2, e;
      logic bp, pe_exp;
      void'($urandom(32'h5eed_0644));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset rx_data", rx_data, 8'h00);
      chk("reset R9 avail", {7'd0, byte_avail}, 8'h00);
      chk("reset R6 perr", {7'd0, par_err}, 8'h00);

      // R3: idle marks do nothing
      for (int i = 0; i < 20; i++) send_bit(1'b1, 0);
      chk("R3 idle marks no byte", {7'd0, byte_avail}, 8'h00);

      // R4 R7 R5 R6 random async characters
      for (int n = 0; n < 60; n++) begin
         @(negedge clk);
         cfg_len8 = 1'($urandom); cfg_odd = 1'($urandom); cfg_par_en = 1'($urandom);
         d = 8'($urandom);
         bp = cfg_par_en && (($urandom % 4) == 0);
         send_char(d, bp, 1'b1, int'($urandom % 5), int'($urandom % 3));
         e = cfg_len8 ? d : {1'b0, d[6:0]};
         pe_exp = bp;
         chk("R4 R7 async data", rx_data, e);
         chk("R9 avail after char", {7'd0, byte_avail}, 8'h01);
         chk("R5 parity flag", {7'd0, par_err}, {7'd0, pe_exp});
         host_read();
         chk("R9 avail cleared by read", {7'd0, byte_avail}, 8'h00);
         if (pe_exp) begin
            // R6: a good character does not clear the flag
            send_char(8'h5a, 1'b0, 1'b1, 0, 0);
            chk("R6 perr sticky", {7'd0, par_err}, 8'h01);
            host_read();
            clear_perr();
            chk("R6 perr cleared", {7'd0, par_err}, 8'h00);
         end
      end

      // R8: space in stop slot discards the character
      @(negedge clk); cfg_len8 = 1'b1; cfg_par_en = 1'b1; cfg_odd = 1'b0;
      send_char(8'hc3, 1'b1, 1'b0, 0, 0);
      chk("R8 no byte on bad stop", {7'd0, byte_avail}, 8'h00);
      chk("R8 no flag on bad stop", {7'd0, par_err}, 8'h00);
      send_char(8'h3c, 1'b0, 1'b1, 2, 0);
      chk("R8 next char after bad stop", rx_data, 8'h3c);
      host_read();

      // R10: overwrite unread byte
      @(negedge clk); cfg_par_en = 1'b0;
      send_char(8'h11, 1'b0, 1'b1, 0, 1);
      send_char(8'hee, 1'b0, 1'b1, 0, 1);
      chk("R10 overwrite data", rx_data, 8'hee);
      chk("R10 avail still set", {7'd0, byte_avail}, 8'h01);
      host_read();

      // R1 random synchronous groups
      @(negedge clk); cfg_async = 1'b0;
      for (int n = 0; n < 20; n++) begin
         d = 8'($urandom);
         for (int i = 0; i < 8; i++) send_bit(d[i], int'($urandom % 2));
         chk("R1 sync group", rx_data, d);
         chk("R1 sync avail", {7'd0, byte_avail}, 8'h01);
         host_read();
      end

      // R2: partial group, leave and re-enter sync mode
      send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
      @(negedge clk); cfg_async = 1'b1;
      send_bit(1'b1, 0);
      @(negedge clk); cfg_async = 1'b0;
      d2 = 8'h96;
      for (int i = 0; i < 8; i++) send_bit(d2[i], 0);
      chk("R2 sync restart at bit 0", rx_data, d2);
      chk("R2 avail", {7'd0, byte_avail}, 8'h01);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule